// File: doc/BRIEF.md
# Indirect Peripheral Clock Configuration Bank

This block keeps a generated-clock setting (source choice, 8-bit divider, enable) for each of up to 64 peripheral slots. All slots sit behind one 32-bit control word on a simple register bus. Software reaches a slot in two steps. A select write points the control word at one slot, and later reads show that slot. A command write stores new fields in the pointed slot. Every slot's stored fields drive the per-peripheral clock generators continuously through flat output vectors.

A small sequencer captures each accepted write and applies it on the next clock edge. It has three states. `ST_IDLE` means nothing is pending. `ST_SELECT` means a captured select write is waiting to move the pointer. `ST_COMMIT` means a captured command write is waiting to move the pointer and update the slot. From any state, the transition is to `ST_SELECT` on a select write, to `ST_COMMIT` on a command write, and to `ST_IDLE` when no write is accepted. Slots 0 and 1 are reserved. They hold no storage and always report zeros.

Control word layout: slot index in bits [5:0], source choice in bits [10:8], command flag in bit 12, divider in bits [27:20], enable in bit 29. All other bits are zero.

Top module: `pcb_bank`

## Requirements
- R1: After reset, every slot output is zero (source 0, divider 0, disabled), the read data is 0, and the pointer is slot 0.
- R2: A write to the control address with bit 12 clear moves the pointer to the index in bits [5:0] one edge after the write is sampled. No slot output changes, whatever the other bits hold.
- R3: A read to the control address updates the read data at the edge where the read is sampled. The read data then holds the pointer in [5:0], the pointed slot's source in [10:8], its divider in [27:20] and its enable in [29], with bit 12 and every other bit reading 0. The read data keeps its value while no read is sampled.
- R4: A write with bit 12 set to a slot index of 2 or more replaces that slot's source, divider and enable with the written fields. The slot's outputs change one edge after the write is sampled, and the pointer moves to that index.
- R5: A command write to slot 0 or 1 leaves every slot unchanged, but still moves the pointer.
- R6: A written source value of 6 or 7 is stored as 0. Values 0 to 5 are stored unchanged.
- R7: Every divider value from 0 to 255 is stored and read back unchanged.
- R8: A read sampled in the same cycle as a write, or in the cycle right after it, returns the contents from before that write. A read two cycles after the write returns the new contents.
- R9: A write to any other address has no effect, and a read to any other address returns 0.
- R10: Writes on consecutive cycles are all applied, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| gclk_src | output | NUM_PERIPH*3 | Source choice per slot, slot i at [3i+2:3i] |
| gclk_div | output | NUM_PERIPH*8 | Divider per slot, slot i at [8i+7:8i] |
| gclk_en | output | NUM_PERIPH | Enable per slot |

## Verification
Two functions can land on the same edge: a read captures the control word while the sequencer is applying an earlier write. The bench provokes this in two ways. In one, a single cycle asserts both the read and command-write strobes and keeps the read strobe high for two more cycles. In the other, command writes go out back to back. The pre-write word is expected twice and the new word on the third read. Back-to-back writes must each take effect, in order.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int IDX_LSB = 0;
    localparam int SRC_LSB = 8;
    localparam int SRC_W   = 3;
    localparam int CMD_BIT = 12;
    localparam int DIV_LSB = 20;
    localparam int DIV_W   = 8;
    localparam int EN_BIT  = 29;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [SRC_W-1:0] src;
    } pcb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_COMMIT = 2'd2
    } pcb_state_t;
endpackage

// File: rtl/pcb_seq.sv
module pcb_seq
    import pcb_pkg::*;
#(
    parameter int NUM_PERIPH  = 64,
    parameter int FIRST_VALID = 2,
    parameter int NUM_SRC     = 6,
    parameter int IW          = $clog2(NUM_PERIPH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [31:0]   wdata,
    output logic [IW-1:0] sel_idx,
    output logic          upd_valid,
    output logic [IW-1:0] upd_idx,
    output pcb_entry_t    upd_entry
);
    pcb_state_t state, state_nx;
    logic [IW-1:0] hold_idx;
    pcb_entry_t    hold_ent;
    logic [SRC_W-1:0] raw_src;
    logic unused_wbits;

    assign raw_src      = wdata[SRC_LSB +: SRC_W];
    assign unused_wbits = ^wdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        if (!wr_hit)              state_nx = ST_IDLE;
        else if (wdata[CMD_BIT])  state_nx = ST_COMMIT;
        else                      state_nx = ST_SELECT;
    end

    // capture and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_idx <= '0;
            hold_ent <= '0;
            sel_idx  <= '0;
        end else begin
            if (wr_hit) begin
                hold_idx     <= wdata[IDX_LSB +: IW];
                hold_ent.src <= (int'(raw_src) >= NUM_SRC) ? '0 : raw_src;
                hold_ent.div <= wdata[DIV_LSB +: DIV_W];
                hold_ent.en  <= wdata[EN_BIT];
            end
            if (state != ST_IDLE) sel_idx <= hold_idx;
        end
    end

    // outputs
    always_comb begin
        upd_idx   = hold_idx;
        upd_entry = hold_ent;
        upd_valid = 1'b0;
        unique case (state)
            ST_IDLE:   upd_valid = 1'b0;
            ST_SELECT: upd_valid = 1'b0;
            ST_COMMIT: upd_valid = (int'(hold_idx) >= FIRST_VALID);
            default:   upd_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcb_slot.sv
module pcb_slot
    import pcb_pkg::*;
#(
    parameter int SLOT = 2,
    parameter int IW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_valid,
    input  logic [IW-1:0] upd_idx,
    input  pcb_entry_t    upd_entry,
    output pcb_entry_t    q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (upd_valid && (upd_idx == IW'(SLOT)))
            q <= upd_entry;
    end
endmodule

// File: rtl/pcb_view.sv
module pcb_view
    import pcb_pkg::*;
#(
    parameter int NUM_PERIPH = 64,
    parameter int IW         = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_any,
    input  logic          rd_hit,
    input  logic [IW-1:0] sel_idx,
    input  pcb_entry_t    ent [NUM_PERIPH],
    output logic [31:0]   rdata
);
    pcb_entry_t cur;
    logic [31:0] word;

    assign cur = ent[sel_idx];

    always_comb begin
        word = '0;
        word[IDX_LSB +: IW]    = sel_idx;
        word[SRC_LSB +: SRC_W] = cur.src;
        word[DIV_LSB +: DIV_W] = cur.div;
        word[EN_BIT]           = cur.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_any) rdata <= rd_hit ? word : '0;
    end
endmodule

// File: rtl/pcb_bank.sv
module pcb_bank
    import pcb_pkg::*;
#(
    parameter int             NUM_PERIPH  = 64,
    parameter int             FIRST_VALID = 2,
    parameter int             NUM_SRC     = 6,
    parameter int             ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic [NUM_PERIPH*SRC_W-1:0] gclk_src,
    output logic [NUM_PERIPH*DIV_W-1:0] gclk_div,
    output logic [NUM_PERIPH-1:0]       gclk_en
);
    localparam int IW = $clog2(NUM_PERIPH);

    logic          wr_hit, rd_hit;
    logic [IW-1:0] sel_idx, upd_idx;
    logic          upd_valid;
    pcb_entry_t    upd_entry;
    pcb_entry_t    ent [NUM_PERIPH];

    assign wr_hit = bus_wr && (bus_addr == REG_ADDR);
    assign rd_hit = bus_rd && (bus_addr == REG_ADDR);

    pcb_seq #(
        .NUM_PERIPH(NUM_PERIPH), .FIRST_VALID(FIRST_VALID),
        .NUM_SRC(NUM_SRC), .IW(IW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
        .sel_idx(sel_idx), .upd_valid(upd_valid),
        .upd_idx(upd_idx), .upd_entry(upd_entry)
    );

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
        if (i < FIRST_VALID) begin : g_rsvd
            assign ent[i] = '0;
        end else begin : g_live
            pcb_slot #(.SLOT(i), .IW(IW)) u_slot (
                .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
                .upd_idx(upd_idx), .upd_entry(upd_entry), .q(ent[i])
            );
        end
        assign gclk_src[i*SRC_W +: SRC_W] = ent[i].src;
        assign gclk_div[i*DIV_W +: DIV_W] = ent[i].div;
        assign gclk_en[i]                 = ent[i].en;
    end

    pcb_view #(.NUM_PERIPH(NUM_PERIPH), .IW(IW)) u_view (
        .clk(clk), .rst_n(rst_n), .rd_any(bus_rd), .rd_hit(rd_hit),
        .sel_idx(sel_idx), .ent(ent), .rdata(bus_rdata)
    );
endmodule

// File: rtl/pcb_chk.sv
module pcb_chk
    import pcb_pkg::*;
#(
    parameter int             NUM_PERIPH  = 64,
    parameter int             FIRST_VALID = 2,
    parameter int             NUM_SRC     = 6,
    parameter int             ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [31:0]                 bus_wdata,
    input logic [31:0]                 bus_rdata,
    input logic [NUM_PERIPH*SRC_W-1:0] gclk_src,
    input logic [NUM_PERIPH*DIV_W-1:0] gclk_div,
    input logic [NUM_PERIPH-1:0]       gclk_en
);
    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == REG_ADDR) && bus_wdata[CMD_BIT];

    p_cmd_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[CMD_BIT] == 1'b0);

    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != REG_ADDR) |=> bus_rdata == 32'd0);

    p_change_needs_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({gclk_src, gclk_div, gclk_en}) |-> $past(cmd_wr, 2));

    p_rsvd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gclk_en[FIRST_VALID-1:0] == '0 &&
        gclk_div[FIRST_VALID*DIV_W-1:0] == '0 &&
        gclk_src[FIRST_VALID*SRC_W-1:0] == '0);

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_src
        p_src_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            int'(gclk_src[i*SRC_W +: SRC_W]) < NUM_SRC);
    end
endmodule

bind pcb_bank pcb_chk #(
    .NUM_PERIPH(NUM_PERIPH), .FIRST_VALID(FIRST_VALID), .NUM_SRC(NUM_SRC),
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (.*);

// File: tb/tb_pcb_bank.sv
`timescale 1ns/1ps
module tb_pcb_bank;
    localparam int N = 64;
    localparam logic [7:0] RA = 8'h0C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N*3-1:0] gclk_src;
    logic [N*8-1:0] gclk_div;
    logic [N-1:0] gclk_en;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [2:0] m_src [N];
    logic [7:0] m_div [N];
    logic       m_en  [N];
    int m_sel = 0;

    always #4 clk = ~clk;

    pcb_bank dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(int idx, int src, int dv, bit en, bit cmd);
        logic [31:0] w = '0;
        w[5:0] = 6'(idx); w[10:8] = 3'(src); w[27:20] = 8'(dv);
        w[29] = en; w[12] = cmd;
        return w;
    endfunction

    function automatic logic [31:0] exp_rd();
        return mkw(m_sel, m_src[m_sel], m_div[m_sel], m_en[m_sel], 1'b0);
    endfunction

    // model update from a command write (R4,R5,R6)
    task automatic model_cmd(int idx, int src, int dv, bit en);
        m_sel = idx;
        if (idx >= 2) begin
            m_src[idx] = (src >= 6) ? 3'd0 : 3'(src);
            m_div[idx] = 8'(dv);
            m_en[idx]  = en;
        end
    endtask

    task automatic chk_outs(input string req);
        logic [N*3-1:0] es; logic [N*8-1:0] ed; logic [N-1:0] ee;
        for (int i = 0; i < N; i++) begin
            es[i*3 +: 3] = m_src[i]; ed[i*8 +: 8] = m_div[i]; ee[i] = m_en[i];
        end
        n_chk++;
        if (gclk_src !== es || gclk_div !== ed || gclk_en !== ee) begin
            n_bad++;
            $display("FAIL %s: outputs actual en=%h expected en=%h (src/div vectors differ=%0d)",
                     req, gclk_en, ee, (gclk_src !== es) || (gclk_div !== ed));
        end
    endtask

    // called at a negedge; returns at the negedge after the write is applied
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        logic [31:0] v, old;
        for (int i = 0; i < N; i++) begin m_src[i] = '0; m_div[i] = '0; m_en[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(bus_rdata, 32'd0, "R1 rdata after reset");
        chk_outs("R1 outputs after reset");
        rd(RA, v); chk(v, 32'd0, "R1 pointer and slot 0 after reset");

        // R9 foreign address
        wr(8'h10, mkw(10, 3, 77, 1, 1));
        chk_outs("R9 foreign write ignored");
        rd(8'h10, v); chk(v, 32'd0, "R9 foreign read zero");
        rd(RA, v); chk(v, exp_rd(), "R9 pointer unchanged");

        // R4 R5 R6 sweep over every slot
        for (int i = 0; i < N; i++) begin
            int s = i % 8; int d = (i * 37 + 11) % 256; bit e = bit'((i / 2) % 2);
            wr(RA, mkw(i, s, d, e, 1'b1));
            model_cmd(i, s, d, e);
            chk_outs(i < 2 ? "R5 reserved slot untouched" : (s >= 6 ? "R6 source clamp" : "R4 command write"));
            rd(RA, v); chk(v, exp_rd(), "R3 readback after command");
        end

        // R2 select writes with junk in the other fields
        for (int i = N - 1; i >= 0; i--) begin
            wr(RA, mkw(i, 7, 255 - i, 1'b1, 1'b0) | 32'hC00E_0CC0);
            m_sel = i;
            chk_outs("R2 select leaves slots");
            rd(RA, v); chk(v, exp_rd(), "R2 R3 readback after select");
        end

        // R7 divider sweep on slot 40
        for (int d = 0; d < 256; d++) begin
            wr(RA, mkw(40, d % 6, d, bit'(d % 2), 1'b1));
            model_cmd(40, d % 6, d, bit'(d % 2));
            chk(32'(gclk_div[40*8 +: 8]), 32'(d), "R7 divider output");
            rd(RA, v); chk(v, exp_rd(), "R7 divider readback");
        end

        // R8 read colliding with a command write
        wr(RA, mkw(20, 0, 0, 1'b0, 1'b0)); m_sel = 20;
        old = exp_rd();
        bus_addr = RA; bus_wdata = mkw(20, 3, 99, 1'b1, 1'b1); bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk(bus_rdata, old, "R8 read in write cycle");
        @(negedge clk);
        chk(bus_rdata, old, "R8 read one cycle after write");
        @(negedge clk); bus_rd = 1'b0;
        model_cmd(20, 3, 99, 1'b1);
        chk(bus_rdata, exp_rd(), "R8 read two cycles after write");

        // R10 back-to-back command writes
        bus_addr = RA; bus_wdata = mkw(7, 5, 201, 1'b1, 1'b1); bus_wr = 1'b1;
        @(negedge clk); bus_wdata = mkw(8, 2, 13, 1'b1, 1'b1);
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
        model_cmd(7, 5, 201, 1'b1); model_cmd(8, 2, 13, 1'b1);
        chk_outs("R10 both writes applied");
        rd(RA, v); chk(v, exp_rd(), "R10 pointer at last write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule